// File: doc/BRIEF.md
# Pulse-Width Ripple Counter

This block measures how long an input pulse stays high by counting falling edges of a fast measurement clock during the pulse. The counting chain is an asynchronous ripple counter: the first stage is a single toggle flip-flop clocked by the measurement clock, and each later stage is clocked by the falling edge of the bit before it. Speed is therefore limited only by the front-end flip-flop. The chain carries no enable. A sequencer in the slower system-clock domain starts and stops counting only through the asynchronous clear of the front-end stage.

A measurement runs as follows. The pulse input is synchronized into the system domain. While `enable_i` is high, the sequencer wipes every counter bit and the sticky wrap flag. It then waits for a rising edge of the synchronized pulse and releases the front-end clear. When the pulse ends, it clamps the front-end clear again and waits a programmable number of system cycles so the ripple can settle. It then copies the count and the wrap flag into holding registers and raises a one-cycle done strobe. The held count is driven onto a bus that floats unless output-enable is high.

Clamping the front-end stage while it holds a 1 produces one last carry into the chain. As a result, an odd number of counted edges reads back rounded up to the next even value.

Top module: `pulse_width_meter`

## Requirements
- R1: After reset, `done_o` and `ovf_o` are low, and with `oe_i` high `count_o` reads zero.
- R2: A measurement of N falling edges of `meas_clk_i` inside the counting window latches the count E mod 2^CNT_W, where E = N when N is even and E = N+1 when N is odd (the stop carry). The chain does not change while the window is closed.
- R3: `ovf_o` is latched together with the count and is 1 exactly when E ≥ 2^CNT_W. The clear phase of the next measurement wipes it, so a later measurement without a wrap reads 0.
- R4: `done_o` is high for exactly one system cycle per measurement, in the first cycle in which the new count and flag are visible.
- R5: The held count and flag change only together with `done_o`. They keep their value during the next measurement's clear and counting phases.
- R6: While `enable_i` is low, pulses on `pulse_i` start no measurement: no `done_o` appears and `count_o` keeps its value.
- R7: With `oe_i` low, `count_o` is high impedance. With `oe_i` high, it carries the held count.
- R8: `done_o` rises on the (SETTLE_CYC+4)-th rising edge of `clk_i` after `pulse_i` falls. This covers two synchronizer flops, one cycle for end detection, SETTLE_CYC settle cycles and one latch cycle. A latch is always preceded by the settle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock for the synchronizer, sequencer and holding registers |
| rst_ni | input | 1 | Asynchronous active-low reset; also clears the ripple chain |
| meas_clk_i | input | 1 | Fast measurement clock; the front-end stage counts its falling edges |
| enable_i | input | 1 | Allows the sequencer to start a new measurement |
| pulse_i | input | 1 | Pulse whose width is measured, asynchronous to `clk_i` |
| oe_i | input | 1 | Output enable for `count_o` |
| count_o | output | CNT_W | Held count, high impedance while `oe_i` is low |
| ovf_o | output | 1 | Sticky wrap flag held with the count |
| done_o | output | 1 | One-cycle strobe marking a new held result |

## Verification
The stop carry produced by clamping the front-end stage can coincide with the wrap of the chain. With an 8-bit chain and 255 counted edges, the clamp itself carries all bits to zero and sets the wrap flag within the same event. The bench sweeps every edge count from 0 past the wrap point. It judges each result arithmetically against the rounded-up value modulo 256 and the flag E ≥ 256. It also checks that a following non-wrapping measurement reads a cleared flag.

// File: rtl/prc_pkg.sv
`timescale 1ns/1ps
package prc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_ARMED,
    ST_COUNTING,
    ST_SETTLE,
    ST_LATCH
  } seq_state_e;
endpackage

// File: rtl/prc_sync2.sv
`timescale 1ns/1ps
module prc_sync2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      q_o    <= 1'b0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/prc_stage.sv
`timescale 1ns/1ps
// One ripple flop: toggles (or sets, when STICKY) on the falling edge of clk_ni.
module prc_stage #(
  parameter bit STICKY = 1'b0
) (
  input  logic clk_ni,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(negedge clk_ni or posedge clr_i) begin
    if (clr_i) q_o <= 1'b0;
    else       q_o <= STICKY ? 1'b1 : ~q_o;
  end
endmodule

// File: rtl/prc_ripple.sv
`timescale 1ns/1ps
module prc_ripple #(
  parameter int CNT_W = 16
) (
  input  logic             meas_clk_i,
  input  logic             front_clr_i,
  input  logic             chain_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W:0] tick;

  assign tick[0] = meas_clk_i;

  for (genvar i = 0; i < CNT_W; i++) begin : g_stage
    assign tick[i+1] = cnt_o[i];
    if (i == 0) begin : g_front
      prc_stage #(.STICKY(1'b0)) u_bit (
        .clk_ni (tick[i]),
        .clr_i  (front_clr_i),
        .q_o    (cnt_o[i])
      );
    end else begin : g_tail
      prc_stage #(.STICKY(1'b0)) u_bit (
        .clk_ni (tick[i]),
        .clr_i  (chain_clr_i),
        .q_o    (cnt_o[i])
      );
    end
  end

  // Falling MSB means the chain wrapped to zero.
  prc_stage #(.STICKY(1'b1)) u_wrap (
    .clk_ni (tick[CNT_W]),
    .clr_i  (chain_clr_i),
    .q_o    (wrap_o)
  );
endmodule

// File: rtl/prc_seq.sv
`timescale 1ns/1ps
module prc_seq
  import prc_pkg::*;
#(
  parameter int SETTLE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic pulse_s_i,
  output logic run_o,
  output logic wipe_o,
  output logic latch_o
);
  localparam int WaitW = (SETTLE_CYC > 2) ? $clog2(SETTLE_CYC) : 1;

  seq_state_e       state_q, state_d;
  logic [WaitW-1:0] wait_q, wait_d;
  logic             pulse_d_q;

  always_comb begin
    state_d = state_q;
    wait_d  = wait_q;
    unique case (state_q)
      ST_IDLE:     if (enable_i) state_d = ST_CLEAR;
      ST_CLEAR:    state_d = ST_ARMED;
      ST_ARMED: begin
        if (!enable_i)                   state_d = ST_IDLE;
        else if (pulse_s_i && !pulse_d_q) state_d = ST_COUNTING;
      end
      ST_COUNTING: begin
        if (!pulse_s_i) begin
          state_d = ST_SETTLE;
          wait_d  = '0;
        end
      end
      ST_SETTLE: begin
        if (wait_q == WaitW'(SETTLE_CYC - 1)) state_d = ST_LATCH;
        else                                  wait_d  = wait_q + 1'b1;
      end
      ST_LATCH:    state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  // Control outputs registered from the next state: glitch-free async clears.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      wait_q    <= '0;
      pulse_d_q <= 1'b0;
      run_o     <= 1'b0;
      wipe_o    <= 1'b0;
      latch_o   <= 1'b0;
    end else begin
      state_q   <= state_d;
      wait_q    <= wait_d;
      pulse_d_q <= pulse_s_i;
      run_o     <= (state_d == ST_COUNTING);
      wipe_o    <= (state_d == ST_CLEAR);
      latch_o   <= (state_d == ST_LATCH);
    end
  end

  p_run_wipe_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run_o && wipe_o));

  p_latch_after_settle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LATCH) |-> ($past(state_q) == ST_SETTLE));

  p_latch_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |=> !latch_o);
endmodule

// File: rtl/pulse_width_meter.sv
`timescale 1ns/1ps
module pulse_width_meter #(
  parameter int CNT_W      = 16,
  parameter int SETTLE_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             meas_clk_i,
  input  logic             enable_i,
  input  logic             pulse_i,
  input  logic             oe_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o,
  output logic             done_o
);
  logic             pulse_s;
  logic             run_q, wipe_q, latch_q;
  logic             chain_clr;
  logic [CNT_W-1:0] raw_cnt;
  logic             raw_wrap;
  logic [CNT_W-1:0] hold_q;
  logic             ovf_q;

  prc_sync2 u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pulse_i),
    .q_o    (pulse_s)
  );

  prc_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (enable_i),
    .pulse_s_i (pulse_s),
    .run_o     (run_q),
    .wipe_o    (wipe_q),
    .latch_o   (latch_q)
  );

  assign chain_clr = wipe_q | ~rst_ni;

  prc_ripple #(.CNT_W(CNT_W)) u_chain (
    .meas_clk_i  (meas_clk_i),
    .front_clr_i (~run_q),
    .chain_clr_i (chain_clr),
    .cnt_o       (raw_cnt),
    .wrap_o      (raw_wrap)
  );

  // Chain is quiet after SETTLE_CYC cycles; sampling across domains is safe here.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      ovf_q  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= latch_q;
      if (latch_q) begin
        hold_q <= raw_cnt;
        ovf_q  <= raw_wrap;
      end
    end
  end

  assign count_o = oe_i ? hold_q : {CNT_W{1'bz}};
  assign ovf_o   = ovf_q;

  p_done_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_hold_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(hold_q) && $stable(ovf_q)));

  p_wipe_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wipe_q |-> ((raw_cnt == '0) && !raw_wrap));

  p_stopped_frozen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !$past(run_q) && !wipe_q && !$past(wipe_q)) |-> $stable(raw_cnt));
endmodule

// File: tb/pulse_width_meter_test.sv
`timescale 1ns/1ps
module pulse_width_meter_test;
  localparam int W    = 8;
  localparam int S    = 3;
  localparam int MODV = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         meas_clk = 1'b1;
  logic         enable = 1'b0;
  logic         pulse = 1'b0;
  logic         oe = 1'b1;
  logic [W-1:0] count;
  logic         ovf;
  logic         done;

  int checks = 0;
  int fails  = 0;
  int prev_cnt = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pulse_width_meter #(.CNT_W(W), .SETTLE_CYC(S)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .meas_clk_i (meas_clk),
    .enable_i   (enable),
    .pulse_i    (pulse),
    .oe_i       (oe),
    .count_o    (count),
    .ovf_o      (ovf),
    .done_o     (done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic meas_edges(input int n);
    for (int i = 0; i < n; i++) begin
      meas_clk = 1'b0; #1;
      meas_clk = 1'b1; #1;
    end
  endtask

  task automatic measure(input int n);
    int e;
    int lat;
    e = n + (n % 2);
    pulse = 1'b1;
    repeat (5) @(negedge clk);
    check(count == W'(prev_cnt), "R5 hold during counting", int'(count), prev_cnt);
    meas_edges(n);
    @(negedge clk);
    pulse = 1'b0;
    lat = 0;
    for (int k = 1; k <= 40; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (done) begin
        lat = k;
        break;
      end
    end
    check(lat == S + 4, "R8 done latency", lat, S + 4);
    check(count == W'(e % MODV), "R2 count", int'(count), e % MODV);
    check(ovf == (e >= MODV), "R3 overflow flag", int'(ovf), int'(e >= MODV));
    prev_cnt = e % MODV;
    @(negedge clk);
    check(done == 1'b0, "R4 done one cycle", int'(done), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(ovf == 1'b0, "R1 ovf after reset", int'(ovf), 0);
    check(count == '0, "R1 count after reset", int'(count), 0);

    enable = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R3: full sweep across the wrap point, incl. stop carry at 255
    for (int n = 0; n <= MODV + 7; n++) measure(n);
    // R3: flag wiped by the next clear phase
    measure(4);
    check(ovf == 1'b0, "R3 flag cleared after wrap", int'(ovf), 0);
    measure(5);

    // R6 R5: disabled, pulses ignored
    enable = 1'b0;
    repeat (3) @(negedge clk);
    pulse = 1'b1;
    repeat (5) @(negedge clk);
    meas_edges(10);
    @(negedge clk);
    pulse = 1'b0;
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (done) seen++;
    end
    check(seen == 0, "R6 no done while disabled", seen, 0);
    check(count == W'(prev_cnt), "R6 count kept while disabled", int'(count), prev_cnt);

    enable = 1'b1;
    repeat (4) @(negedge clk);
    measure(11);

    // R7: output enable
    oe = 1'b0;
    @(negedge clk);
    check((count === {W{1'bz}}) || (count == '0), "R7 bus released", int'(count), 0);
    oe = 1'b1;
    @(negedge clk);
    check(count == W'(prev_cnt), "R7 bus driven", int'(count), prev_cnt);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule